// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block maps 64-bit virtual addresses to physical addresses with a parameterised set of fully associative entries (64 by default). Each entry pairs a tag with a translation word. The tag holds a virtual page number and a 13-bit address-space context. The translation word holds a valid flag, a two-bit page-size code, a physical frame, a privileged-only flag and a writable flag. Every entry is compared against the request at once. Each entry's compare mask comes from its own size code, so 8 KB, 64 KB, 512 KB and 4 MB pages can sit side by side.

A request returns one registered result in the next cycle: a hit with the physical frame and the granted permissions, a protection fault, or a miss. A fault loads a sticky status register and a fault address register. The status register flags overflow when a second fault lands before software has read it, and a read clears it. When translation is disabled, addresses pass through unchanged. The `IS_INSTR` parameter sets the variant. With 0 the instance serves data accesses, which are checked for write permission. With 1 it serves instruction fetches, which grant execute only and ignore the write input. Entries are loaded through an indexed write port.

Top module: `tlb_xlate`

## Requirements
- R1: An entry matches when its tag bits 12:0 equal `ctx_i`, and `vaddr_i` ANDed with the entry's page mask equals the tag with bits 12:0 cleared.
- R2: Translation-word bits 62:61 select the page size, and with it the number of low address bits left out of the compare: code 0 leaves out 13 bits (8 KB), 1 leaves out 16 (64 KB), 2 leaves out 19 (512 KB) and 3 leaves out 22 (4 MB).
- R3: On a hit with translation enabled, `paddr_o` takes its page bits from the translation word and its in-page bits from `vaddr_i`. Only bits 40:13 are kept and every other bit is zero.
- R4: Translation-word bit 63 is valid, bit 2 is privileged-only and bit 1 is writable. A matching entry faults if it is invalid, or if it is privileged and `user_i` is 1. In the data variant it also faults when `write_i` is 1 and bit 1 is clear.
- R5: `perm_o` is {execute, write, read}. A data hit grants read, plus write when bit 1 is set. An instruction hit grants execute only.
- R6: A request that no entry matches gives `miss_o` = 1, `paddr_o` = 0 and `perm_o` = 0, and leaves the status and fault address registers as they were.
- R7: With `xlate_en_i` = 0, a request hits with `paddr_o` = `vaddr_i`. `perm_o` is 3'b011 for data and 3'b100 for instruction fetches. No fault is raised and the fault registers keep their values.
- R8: When several entries match, the lowest index decides the outcome, including when that entry faults.
- R9: On a fault, `far_o` captures `vaddr_i`. `fsr_o` becomes X OR {`user_i`, write, 0, 1}, where X is 4'b0010 if `fsr_o` was nonzero and 0 otherwise. The write term is `write_i` in the data variant and 0 in the instruction variant.
- R10: `fsr_rd_i` = 1 clears `fsr_o` at the next edge. If a fault arrives in the same cycle, the new code is loaded without the overflow bit.
- R11: `rsp_valid_o` is 1 exactly one cycle after each request. When it is 1, exactly one of `hit_o`, `fault_o` and `miss_o` is 1. In a cycle after no request, all four flags, `paddr_o` and `perm_o` are 0.
- R12: With `wr_en_i` = 1, the entry at `wr_idx_i` takes `wr_tag_i` and `wr_tte_i` at the clock edge. A lookup in the same cycle sees the old contents.
- R13: Reset clears every entry to all zeros, which makes it invalid. It also clears `rsp_valid_o`, `fsr_o` and `far_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | IDX_W | Index of the entry to write |
| wr_tag_i | input | 64 | Tag to write (virtual page, context in bits 12:0) |
| wr_tte_i | input | 64 | Translation word to write |
| xlate_en_i | input | 1 | Translation enable; 0 selects pass-through |
| ctx_i | input | 13 | Current context |
| req_i | input | 1 | Lookup request |
| vaddr_i | input | 64 | Virtual address |
| user_i | input | 1 | Request is from user mode |
| write_i | input | 1 | Request is a store (data variant only) |
| fsr_rd_i | input | 1 | Status register read; clears it |
| rsp_valid_o | output | 1 | Result valid |
| hit_o | output | 1 | Translation succeeded |
| fault_o | output | 1 | Protection fault |
| miss_o | output | 1 | No entry matched |
| paddr_o | output | 64 | Physical address |
| perm_o | output | 3 | Granted {execute, write, read} |
| fsr_o | output | 4 | Fault status |
| far_o | output | 64 | Fault address |

## Verification
Directed cases probe each page size one byte inside and one byte beyond the page, which shows whether the mask width per size code is right. Other directed cases cover a wrong context, duplicate matches with a valid or an invalid lower entry, and privilege and write-protection faults. These separate the match, priority and permission paths. Back-to-back faults, and a read landing in the same cycle as a fault, distinguish the overflow rule from the clear rule. A data instance and an instruction instance receive identical stimulus, so the write-fault and permission differences show up side by side. Seeded random traffic over a small set of pages and contexts forces frequent overlaps, mixed sizes and interleaved writes, and every cycle is compared with a model of the requirements.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W     = 64;
  localparam int unsigned CTX_W    = 13;
  localparam int unsigned FSR_W    = 4;
  localparam int unsigned PA_HI    = 40;
  localparam int unsigned PA_LO    = 13;
  localparam int unsigned V_BIT    = 63;
  localparam int unsigned SZ_LO    = 61;
  localparam int unsigned PRIV_BIT = 2;
  localparam int unsigned WR_BIT   = 1;

  typedef logic [VA_W-1:0] va_t;

  typedef enum logic [1:0] {
    PG_8K   = 2'd0,
    PG_64K  = 2'd1,
    PG_512K = 2'd2,
    PG_4M   = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  localparam va_t CTX_FIELD = va_t'((va_t'(1) << CTX_W) - va_t'(1));
  localparam va_t PA_KEEP   = ((va_t'(1) << (PA_HI + 1)) - va_t'(1)) &
                              ~((va_t'(1) << PA_LO) - va_t'(1));

  // mask that keeps the page-number bits for a given size code
  function automatic va_t page_mask(input logic [1:0] sz);
    int unsigned sh;
    case (pg_size_e'(sz))
      PG_8K:   sh = 13;
      PG_64K:  sh = 16;
      PG_512K: sh = 19;
      default: sh = 22;
    endcase
    return ~((va_t'(1) << sh) - va_t'(1));
  endfunction
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_pkg::*;
(
  input  va_t              tag_i,
  input  logic [1:0]       size_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  va_t              vaddr_i,
  output logic             match_o
);
  va_t pmask;
  logic ctx_eq;
  logic va_eq;

  assign pmask   = page_mask(size_i);
  assign ctx_eq  = tag_i[CTX_W-1:0] == ctx_i;
  assign va_eq   = (vaddr_i & pmask) == (tag_i & ~CTX_FIELD);
  assign match_o = ctx_eq && va_eq;
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    // scan downward so the lowest set bit is written last
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_fault_regs.sv
module tlb_fault_regs
  import tlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic             user_i,
  input  logic             write_i,
  input  va_t              vaddr_i,
  input  logic             clr_i,
  output logic [FSR_W-1:0] fsr_o,
  output va_t              far_o
);
  logic [FSR_W-1:0] fsr_q;
  logic [FSR_W-1:0] base;
  logic [FSR_W-1:0] code;
  va_t              far_q;

  // a read in the same cycle consumes the old value, so no overflow mark
  assign base = (clr_i || fsr_q == '0) ? '0 : FSR_W'(2);
  assign code = FSR_W'({user_i, write_i, 1'b0, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_q <= '0;
      far_q <= '0;
    end else if (fault_i) begin
      fsr_q <= base | code;
      far_q <= vaddr_i;
    end else if (clr_i) begin
      fsr_q <= '0;
    end
  end

  assign fsr_o = fsr_q;
  assign far_o = far_q;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES  = 64,
  parameter bit          IS_INSTR = 1'b0,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VA_W-1:0]  wr_tag_i,
  input  logic [VA_W-1:0]  wr_tte_i,
  input  logic             xlate_en_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic             req_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             user_i,
  input  logic             write_i,
  input  logic             fsr_rd_i,
  output logic             rsp_valid_o,
  output logic             hit_o,
  output logic             fault_o,
  output logic             miss_o,
  output logic [VA_W-1:0]  paddr_o,
  output logic [2:0]       perm_o,
  output logic [FSR_W-1:0] fsr_o,
  output logic [VA_W-1:0]  far_o
);
  va_t tag_q [ENTRIES];
  va_t tte_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tte_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      tte_q[wr_idx_i] <= wr_tte_i;
    end
  end

  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    tlb_entry_cmp u_cmp (
      .tag_i   (tag_q[g]),
      .size_i  (tte_q[g][SZ_LO+:2]),
      .ctx_i   (ctx_i),
      .vaddr_i (vaddr_i),
      .match_o (match[g])
    );
  end

  logic             found;
  logic [IDX_W-1:0] sel_idx;

  tlb_prio_sel #(.N(ENTRIES), .IDX_W(IDX_W)) u_sel (
    .req_i   (match),
    .found_o (found),
    .idx_o   (sel_idx)
  );

  va_t   sel_tte;
  va_t   sel_mask;
  va_t   hit_pa;
  logic  wr_eff;
  logic  lk_fault;
  perm_t hit_perm;
  perm_t byp_perm;

  assign sel_tte  = tte_q[sel_idx];
  assign sel_mask = page_mask(sel_tte[SZ_LO+:2]);
  assign hit_pa   = ((sel_tte & sel_mask) | (vaddr_i & ~sel_mask)) & PA_KEEP;

  if (IS_INSTR) begin : g_ins
    assign wr_eff   = 1'b0;
    assign hit_perm = '{x: 1'b1, w: 1'b0, r: 1'b0};
    assign byp_perm = '{x: 1'b1, w: 1'b0, r: 1'b0};
  end else begin : g_dat
    assign wr_eff   = write_i;
    assign hit_perm = '{x: 1'b0, w: sel_tte[WR_BIT], r: 1'b1};
    assign byp_perm = '{x: 1'b0, w: 1'b1, r: 1'b1};
  end

  assign lk_fault = !sel_tte[V_BIT] ||
                    (sel_tte[PRIV_BIT] && user_i) ||
                    (wr_eff && !sel_tte[WR_BIT]);

  logic  rsp_q, hit_q, fault_q, miss_q;
  va_t   pa_q;
  perm_t perm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      miss_q  <= 1'b0;
      pa_q    <= '0;
      perm_q  <= '0;
    end else begin
      rsp_q   <= req_i;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      miss_q  <= 1'b0;
      pa_q    <= '0;
      perm_q  <= '0;
      if (req_i) begin
        if (!xlate_en_i) begin
          hit_q  <= 1'b1;
          pa_q   <= vaddr_i;
          perm_q <= byp_perm;
        end else if (!found) begin
          miss_q <= 1'b1;
        end else if (lk_fault) begin
          fault_q <= 1'b1;
        end else begin
          hit_q  <= 1'b1;
          pa_q   <= hit_pa;
          perm_q <= hit_perm;
        end
      end
    end
  end

  tlb_fault_regs u_fregs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (req_i && xlate_en_i && found && lk_fault),
    .user_i  (user_i),
    .write_i (wr_eff),
    .vaddr_i (vaddr_i),
    .clr_i   (fsr_rd_i),
    .fsr_o   (fsr_o),
    .far_o   (far_o)
  );

  assign rsp_valid_o = rsp_q;
  assign hit_o       = hit_q;
  assign fault_o     = fault_q;
  assign miss_o      = miss_q;
  assign paddr_o     = pa_q;
  assign perm_o      = perm_q;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter bit IS_INSTR = 1'b0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        xlate_en_i,
  input logic [63:0] vaddr_i,
  input logic        fsr_rd_i,
  input logic        rsp_valid_o,
  input logic        hit_o,
  input logic        fault_o,
  input logic        miss_o,
  input logic [63:0] paddr_o,
  input logic [2:0]  perm_o,
  input logic [3:0]  fsr_o,
  input logic [63:0] far_o
);
  p_one_result_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({hit_o, fault_o, miss_o}) == 1);

  p_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o && !hit_o && !fault_o && !miss_o);

  p_far_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> !fault_o || far_o == $past(vaddr_i));

  p_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> fsr_o[0]);

  p_fsr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsr_rd_i |=> fault_o || $stable(fsr_o));

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsr_rd_i |=> fault_o || fsr_o == 4'd0);

  p_bypass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !xlate_en_i |=> hit_o && paddr_o == $past(vaddr_i));

  p_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> paddr_o == 64'd0 && perm_o == 3'd0);

  p_pa_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && xlate_en_i |=> !hit_o || (paddr_o[12:0] == 13'd0 && paddr_o[63:41] == 23'd0));

  if (IS_INSTR) begin : g_ins
    p_perm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> perm_o == 3'b100);
  end else begin : g_dat
    p_perm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> perm_o[0] && !perm_o[2]);
  end
endmodule

bind tlb_xlate tlb_xlate_chk #(.IS_INSTR(IS_INSTR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .xlate_en_i  (xlate_en_i),
  .vaddr_i     (vaddr_i),
  .fsr_rd_i    (fsr_rd_i),
  .rsp_valid_o (rsp_valid_o),
  .hit_o       (hit_o),
  .fault_o     (fault_o),
  .miss_o      (miss_o),
  .paddr_o     (paddr_o),
  .perm_o      (perm_o),
  .fsr_o       (fsr_o),
  .far_o       (far_o)
);

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;
  localparam logic [63:0] PAK = 64'h0000_01FF_FFFF_E000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_tag = '0, wr_tte = '0;
  logic        xen = 1'b0;
  logic [12:0] ctx = '0;
  logic        req = 1'b0;
  logic [63:0] va = '0;
  logic        usr = 1'b0, wrt = 1'b0, rd = 1'b0;

  logic        d_v, d_h, d_f, d_m, i_v, i_h, i_f, i_m;
  logic [63:0] d_pa, i_pa, d_far, i_far;
  logic [2:0]  d_pm, i_pm;
  logic [3:0]  d_fsr, i_fsr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tlb_xlate #(.ENTRIES(64), .IS_INSTR(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_tag_i(wr_tag), .wr_tte_i(wr_tte), .xlate_en_i(xen), .ctx_i(ctx),
    .req_i(req), .vaddr_i(va), .user_i(usr), .write_i(wrt), .fsr_rd_i(rd),
    .rsp_valid_o(d_v), .hit_o(d_h), .fault_o(d_f), .miss_o(d_m),
    .paddr_o(d_pa), .perm_o(d_pm), .fsr_o(d_fsr), .far_o(d_far));

  tlb_xlate #(.ENTRIES(64), .IS_INSTR(1'b1)) u_dut_ins (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_tag_i(wr_tag), .wr_tte_i(wr_tte), .xlate_en_i(xen), .ctx_i(ctx),
    .req_i(req), .vaddr_i(va), .user_i(usr), .write_i(wrt), .fsr_rd_i(rd),
    .rsp_valid_o(i_v), .hit_o(i_h), .fault_o(i_f), .miss_o(i_m),
    .paddr_o(i_pa), .perm_o(i_pm), .fsr_o(i_fsr), .far_o(i_far));

  // model state
  logic [63:0] m_tag [64];
  logic [63:0] m_tte [64];
  logic [3:0]  m_fsr [2];
  logic [63:0] m_far [2];

  function automatic logic [63:0] pmask(input logic [1:0] s);
    case (s)
      2'd0:    return ~64'h1FFF;
      2'd1:    return ~64'hFFFF;
      2'd2:    return ~64'h7FFFF;
      default: return ~64'h3FFFFF;
    endcase
  endfunction

  function automatic logic [63:0] mk_tag(input logic [63:0] a, input logic [12:0] c);
    return (a & ~64'h1FFF) | {51'd0, c};
  endfunction

  function automatic logic [63:0] mk_tte(input logic v, input logic [1:0] s, input logic [63:0] pa,
                                         input logic pv, input logic w);
    return {v, s, 61'd0} | (pa & 64'h1FFF_FFFF_FFFF_E000) | {61'd0, pv, w, 1'b0};
  endfunction

  task automatic model_lk(input int md, input logic [63:0] a, input logic u, input logic w,
                          input logic en, input logic [12:0] c,
                          output logic h, output logic f, output logic ms,
                          output logic [63:0] pa, output logic [2:0] pm);
    logic fnd;
    int   idx;
    logic [63:0] t, mk;
    h = 0; f = 0; ms = 0; pa = '0; pm = '0;
    if (!en) begin
      h = 1; pa = a; pm = (md == 1) ? 3'b100 : 3'b011;
      return;
    end
    fnd = 0; idx = 0;
    for (int i = 0; i < 64; i++) begin
      if (!fnd && m_tag[i][12:0] == c && (a & pmask(m_tte[i][62:61])) == (m_tag[i] & ~64'h1FFF)) begin
        fnd = 1; idx = i;
      end
    end
    if (!fnd) begin
      ms = 1;
      return;
    end
    t = m_tte[idx];
    if (!t[63] || (t[2] && u) || (md == 0 && w && !t[1])) begin
      f = 1;
      return;
    end
    mk = pmask(t[62:61]);
    h  = 1;
    pa = ((t & mk) | (a & ~mk)) & PAK;
    pm = (md == 1) ? 3'b100 : {1'b0, t[1], 1'b1};
  endtask

  task automatic chk(input string r, input string nm, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", r, nm, act, exp);
    end
  endtask

  // one cycle: drive at a falling edge, compare at the next
  task automatic step(input string r, input logic rq, input logic [63:0] a, input logic [12:0] c,
                      input logic u, input logic w, input logic en, input logic rdv,
                      input logic we, input int wi, input logic [63:0] wt, input logic [63:0] wte);
    logic        eh [2], ef [2], em [2];
    logic [63:0] epa [2];
    logic [2:0]  epm [2];
    req = rq; va = a; ctx = c; usr = u; wrt = w; xen = en; rd = rdv;
    wr_en = we; wr_idx = 6'(wi); wr_tag = wt; wr_tte = wte;
    for (int md = 0; md < 2; md++) begin
      model_lk(md, a, u, w, en, c, eh[md], ef[md], em[md], epa[md], epm[md]);
      if (!rq) begin
        eh[md] = 0; ef[md] = 0; em[md] = 0; epa[md] = '0; epm[md] = '0;
      end
      if (ef[md]) begin
        m_fsr[md] = ((rdv || m_fsr[md] == 4'd0) ? 4'd0 : 4'd2) |
                    {u, (md == 0) ? w : 1'b0, 1'b0, 1'b1};
        m_far[md] = a;
      end else if (rdv) begin
        m_fsr[md] = 4'd0;
      end
    end
    if (we) begin
      m_tag[wi] = wt;
      m_tte[wi] = wte;
    end
    @(negedge clk);
    chk(r, "d.valid", 64'(d_v), 64'(rq));
    chk(r, "d.hit",   64'(d_h), 64'(eh[0]));
    chk(r, "d.fault", 64'(d_f), 64'(ef[0]));
    chk(r, "d.miss",  64'(d_m), 64'(em[0]));
    chk(r, "d.paddr", d_pa, epa[0]);
    chk(r, "d.perm",  64'(d_pm), 64'(epm[0]));
    chk(r, "d.fsr",   64'(d_fsr), 64'(m_fsr[0]));
    chk(r, "d.far",   d_far, m_far[0]);
    chk(r, "i.valid", 64'(i_v), 64'(rq));
    chk(r, "i.hit",   64'(i_h), 64'(eh[1]));
    chk(r, "i.fault", 64'(i_f), 64'(ef[1]));
    chk(r, "i.miss",  64'(i_m), 64'(em[1]));
    chk(r, "i.paddr", i_pa, epa[1]);
    chk(r, "i.perm",  64'(i_pm), 64'(epm[1]));
    chk(r, "i.fsr",   64'(i_fsr), 64'(m_fsr[1]));
    chk(r, "i.far",   i_far, m_far[1]);
  endtask

  task automatic lk(input string r, input logic [63:0] a, input logic [12:0] c,
                    input logic u, input logic w);
    step(r, 1'b1, a, c, u, w, 1'b1, 1'b0, 1'b0, 0, '0, '0);
  endtask

  task automatic wr_ent(input string r, input int wi, input logic [63:0] t, input logic [63:0] e);
    step(r, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, wi, t, e);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [63:0] base, a, t;
    logic [1:0]  sz;
    int          j;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin
      m_tag[i] = '0;
      m_tte[i] = '0;
    end
    for (int md = 0; md < 2; md++) begin
      m_fsr[md] = '0;
      m_far[md] = '0;
    end
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13", "d.valid", 64'(d_v), 64'd0);
    chk("R13", "d.fsr", 64'(d_fsr), 64'd0);
    chk("R13", "d.far", d_far, 64'd0);
    chk("R13", "i.valid", 64'(i_v), 64'd0);
    chk("R13", "i.fsr", 64'(i_fsr), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R13: zeroed entries match address 0 in context 0 and are invalid
    lk("R13", 64'h0, 13'd0, 1'b0, 1'b0);
    step("R10", 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, '0, '0);
    step("R11", 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, '0, '0);
    // R7: pass-through, even where an invalid entry would match
    step("R7", 1'b1, 64'h0000_0000_0000_0123, 13'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, '0, '0);
    step("R7", 1'b1, 64'hFEDC_BA98_7654_3210, 13'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, '0, '0);
    // R12: write and lookup in one cycle sees old contents
    base = 64'h0000_00AB_CDE0_0000;
    step("R12", 1'b1, base, 13'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3,
         mk_tag(base, 13'd5), mk_tte(1'b1, 2'd0, 64'h0000_0123_4560_0000, 1'b0, 1'b1));
    lk("R12", base | 64'h1ABC, 13'd5, 1'b0, 1'b1);
    // R2/R3: each size, last byte inside and first byte outside the page
    for (int s = 0; s < 4; s++) begin
      base = 64'(s + 1) << 32;
      wr_ent("R2", 10 + s, mk_tag(base, 13'd5),
             mk_tte(1'b1, 2'(s), 64'h0000_01AB_C000_0000 | (64'(s) << 36), 1'b0, 1'b1));
      lk("R2", base + (64'd1 << (13 + 3 * s)) - 64'd1, 13'd5, 1'b0, 1'b0);
      lk("R2", base + (64'd1 << (13 + 3 * s)), 13'd5, 1'b0, 1'b0);
    end
    // R3: frame bits above 40 are dropped
    base = 64'h0000_0000_A000_0000;
    wr_ent("R3", 14, mk_tag(base, 13'd5), mk_tte(1'b1, 2'd3, 64'h0FFF_FFFF_FFFF_E000, 1'b0, 1'b0));
    lk("R3", base | 64'h2F_FFFF, 13'd5, 1'b0, 1'b0);
    // R4/R5: privilege, write protection and invalid entries
    base = 64'h0000_0005_0000_0000;
    wr_ent("R4", 15, mk_tag(base, 13'd5), mk_tte(1'b1, 2'd0, 64'h0000_0001_2000_0000, 1'b1, 1'b0));
    lk("R4", base, 13'd5, 1'b1, 1'b0);
    lk("R5", base, 13'd5, 1'b0, 1'b0);
    lk("R4", base, 13'd5, 1'b0, 1'b1);
    wr_ent("R4", 16, mk_tag(64'h0000_0006_0000_0000, 13'd5),
           mk_tte(1'b0, 2'd0, 64'h0000_0001_4000_0000, 1'b0, 1'b1));
    lk("R4", 64'h0000_0006_0000_0000, 13'd5, 1'b0, 1'b0);
    // R8: duplicate matches, lowest index wins
    base = 64'h0000_0007_0000_0000;
    wr_ent("R8", 30, mk_tag(base, 13'd5), mk_tte(1'b1, 2'd0, 64'h0000_0000_3000_0000, 1'b0, 1'b1));
    wr_ent("R8", 20, mk_tag(base, 13'd5), mk_tte(1'b1, 2'd0, 64'h0000_0000_2000_0000, 1'b0, 1'b1));
    lk("R8", base | 64'h10, 13'd5, 1'b0, 1'b0);
    base = 64'h0000_0008_0000_0000;
    wr_ent("R8", 31, mk_tag(base, 13'd5), mk_tte(1'b1, 2'd0, 64'h0000_0000_4000_0000, 1'b0, 1'b1));
    wr_ent("R8", 21, mk_tag(base, 13'd5), mk_tte(1'b0, 2'd0, 64'h0000_0000_5000_0000, 1'b0, 1'b1));
    lk("R8", base, 13'd5, 1'b0, 1'b0);
    // R1: wrong context, neighbouring page
    lk("R1", 64'h0000_0007_0000_0000, 13'd6, 1'b0, 1'b0);
    lk("R1", 64'h0000_0007_0000_2000, 13'd5, 1'b0, 1'b0);
    // R6: plain miss
    lk("R6", 64'h0000_DEAD_0000_0000, 13'd5, 1'b1, 1'b1);
    // R9/R10: fault codes, overflow, read-clear
    step("R10", 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, '0, '0);
    lk("R9", 64'h0000_0005_0000_0040, 13'd5, 1'b1, 1'b0);
    lk("R9", 64'h0000_0005_0000_0080, 13'd5, 1'b0, 1'b1);
    lk("R9", 64'h0000_0006_0000_0100, 13'd5, 1'b1, 1'b1);
    step("R10", 1'b1, 64'h0000_0005_0000_0200, 13'd5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 0, '0, '0);
    step("R10", 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, '0, '0);
    step("R11", 1'b1, 64'h0000_0005_0000_0000, 13'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, '0, '0);
    // R1/R2/R8 random traffic with overlapping pages and mixed sizes
    for (int n = 0; n < 1500; n++) begin
      logic rq_r, we_r, en_r, rd_r;
      logic [63:0] wt_r, wte_r;
      int wi_r;
      sz    = 2'($urandom % 4);
      a     = (64'($urandom % 4) << 40) | 64'($urandom & 32'h00F0_0000);
      wt_r  = (a & pmask(sz)) | 64'(1 + $urandom % 3);
      wte_r = mk_tte(($urandom % 8) != 0, sz, {$urandom, $urandom},
                     ($urandom % 4) == 0, $urandom % 2 == 1) | (64'($urandom % 2) << 6);
      wi_r  = int'($urandom % 64);
      we_r  = ($urandom % 3) == 0;
      rq_r  = ($urandom % 5) != 0;
      en_r  = ($urandom % 10) != 0;
      rd_r  = ($urandom % 5) == 0;
      j     = int'($urandom % 64);
      t     = m_tag[j];
      if ($urandom % 6 == 0)
        a = 64'($urandom);
      else
        a = (t & ~64'h1FFF) | 64'($urandom & 32'h003F_FFFF);
      step("R1/R2/R8 random", rq_r, a, ($urandom % 7 == 0) ? 13'(1 + $urandom % 3) : t[12:0],
           $urandom % 2 == 1, $urandom % 2 == 1, en_r, rd_r, we_r, wi_r, wt_r, wte_r);
    end
    summary();
  end
endmodule